// File: doc/BRIEF.md
# Master Serial Configuration Loader

This block sits on the device side of a serial configuration link and pulls a configuration image out of an external sequential memory. After power-up, or after a reconfigure request, it looks at three mode-select inputs once. If all three read zero, it holds the memory's address counter in reset through an active-low init output for a fixed number of cycles. It then releases that reset and produces a slow configuration clock by dividing the system clock. On every rising edge of that clock it takes one bit from the serial data line.

Bits are packed into words with the first bit in the most significant position. Each finished word is handed out on a valid/ready interface. The bench and the design both treat that interface as lossless. While a word waits and ready is low, the block holds back the next rising edge of the configuration clock. This stops the memory, so that nothing is lost. Once the parameterised number of image bits has arrived, the block raises its done output. Done also drives the memory's chip-enable, which puts the memory into standby. The configuration clock then stays low. Pulling the reconfigure input low at any time discards all progress and starts the sequence again.

Top module: `serial_cfg_loader`

## Requirements
- R1: The mode inputs are sampled only in the first clock cycle after reset or after reconfig_n returns high. If they read 3'b000, loading starts. Otherwise the block stays idle with init_n low and cfg_clk low, and a later change of the mode inputs has no effect until the next reconfigure request.
- R2: Serial bits are packed MSB-first: the first bit taken for a word lands in out_data[7], the eighth in out_data[0], and the words leave in the order the bits arrived.
- R3: cfg_clk is low outside the loading phase. During loading it has a period of 2*DIV system cycles, with DIV cycles high and DIV cycles low, and it rises only while loading. cfg_din is sampled in the system cycle in which cfg_clk goes high.
- R4: init_n is low during reset, during idle and for INIT_CYCLES cycles after the start decision. It goes high when loading begins and stays high while loading and while done.
- R5: done goes high in the cycle after the IMAGE_BITS-th bit is taken. It then stays high until the next reconfigure request. cfg_clk returns low one cycle after done rises and produces no further edge.
- R6: When out_valid is high and out_ready is low, out_valid stays high and out_data stays unchanged in the next cycle. A word is consumed in a cycle where out_valid and out_ready are both high. out_valid is low after reset.
- R7: While out_valid is high and out_ready is low, no rising edge of cfg_clk occurs. The pending rise is issued in the first cycle in which that condition clears.
- R8: While reconfig_n is low, the block returns to idle, drives init_n low, done low and cfg_clk low, drops any pending word and forgets all received bits. After release, loading restarts from the first image bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 3 | Mode-select pins; 3'b000 selects serial loading |
| reconfig_n | input | 1 | Active-low reconfigure request |
| cfg_din | input | 1 | Serial data from the configuration memory |
| cfg_clk | output | 1 | Configuration clock to the memory |
| init_n | output | 1 | Active-low reset of the memory address counter |
| done | output | 1 | Load complete; drives the memory chip-enable (high = standby) |
| out_valid | output | 1 | Assembled word available |
| out_ready | input | 1 | Consumer accepts the word |
| out_data | output | 8 | Assembled configuration word |

## Verification
The interesting collision is a scheduled rising edge of the configuration clock that falls in the same cycle as an unaccepted word on the output. In that cycle the edge must be withheld, not dropped or taken twice. The bench provokes this by driving out_ready in an irregular on/off pattern while an image streams in. A behavioural model in the bench follows every cycle and compares cfg_clk, out_valid and out_data each cycle. At the end, the collected words must equal the image byte for byte, which shows that no bit was skipped or repeated at a stall. Reconfigure requests arriving with a word still pending, and the capture of the final bit, are also checked against the same model.

// File: rtl/serial_cfg_loader_pkg.sv
package serial_cfg_loader_pkg;

  typedef enum logic [1:0] {
    LD_IDLE     = 2'd0,
    LD_RESET    = 2'd1,
    LD_SHIFT    = 2'd2,
    LD_FINISHED = 2'd3
  } ld_state_t;

  localparam int unsigned MODE_W = 3;

endpackage

// File: rtl/cfgl_sequencer.sv
module cfgl_sequencer
  import serial_cfg_loader_pkg::*;
#(
  parameter int unsigned INIT_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reconfig_n,
  input  logic [MODE_W-1:0] mode_sel,
  input  logic              last_bit,
  output ld_state_t         state,
  output logic              init_n,
  output logic              done,
  output logic              shifting
);

  localparam int unsigned IC_W = (INIT_CYCLES > 1) ? $clog2(INIT_CYCLES) : 1;
  localparam logic [IC_W-1:0] IC_LAST = IC_W'(INIT_CYCLES - 1);

  logic            arm_q;
  logic [IC_W-1:0] icnt_q;

  // The start latch gives one look at the mode pins per start event
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= LD_IDLE;
      arm_q  <= 1'b1;
      icnt_q <= '0;
    end else if (!reconfig_n) begin
      state  <= LD_IDLE;
      arm_q  <= 1'b1;
      icnt_q <= '0;
    end else begin
      unique case (state)
        LD_IDLE: begin
          if (arm_q) begin
            arm_q <= 1'b0;
            if (mode_sel == '0) begin
              state  <= LD_RESET;
              icnt_q <= '0;
            end
          end
        end
        LD_RESET: begin
          if (icnt_q == IC_LAST) begin
            state <= LD_SHIFT;
          end else begin
            icnt_q <= icnt_q + 1'b1;
          end
        end
        LD_SHIFT: begin
          if (last_bit) begin
            state <= LD_FINISHED;
          end
        end
        LD_FINISHED: begin
          state <= LD_FINISHED;
        end
        default: state <= LD_IDLE;
      endcase
    end
  end

  always_comb begin
    init_n   = (state == LD_SHIFT) || (state == LD_FINISHED);
    done     = (state == LD_FINISHED);
    shifting = (state == LD_SHIFT) && reconfig_n;
  end

endmodule

// File: rtl/cfgl_clkgen.sv
module cfgl_clkgen #(
  parameter int unsigned DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic stall,
  output logic cfg_clk,
  output logic rise
);

  localparam int unsigned PH_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(DIV - 1);

  logic [PH_W-1:0] phase_q;
  logic            clk_q;
  logic            edge_due;

  always_comb begin
    edge_due = run && (phase_q == PH_LAST);
    rise     = edge_due && !clk_q && !stall;
  end

  // A due rising edge is held at the end of the low phase while stalled
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      clk_q   <= 1'b0;
    end else if (!run) begin
      phase_q <= '0;
      clk_q   <= 1'b0;
    end else if (edge_due) begin
      if (clk_q) begin
        clk_q   <= 1'b0;
        phase_q <= '0;
      end else if (!stall) begin
        clk_q   <= 1'b1;
        phase_q <= '0;
      end
    end else begin
      phase_q <= phase_q + 1'b1;
    end
  end

  assign cfg_clk = clk_q;

endmodule

// File: rtl/cfgl_deser.sv
module cfgl_deser #(
  parameter int unsigned WORD_W     = 8,
  parameter int unsigned IMAGE_BITS = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              rise,
  input  logic              din,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data,
  output logic              stall,
  output logic              last_bit
);

  localparam int unsigned BIT_W  = $clog2(IMAGE_BITS + 1);
  localparam int unsigned LANE_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [BIT_W-1:0]  BIT_LAST  = BIT_W'(IMAGE_BITS - 1);
  localparam logic [LANE_W-1:0] LANE_LAST = LANE_W'(WORD_W - 1);

  logic [BIT_W-1:0]  bits_q;
  logic [LANE_W-1:0] lane_q;
  logic [WORD_W-1:0] sh_q;
  logic [WORD_W-1:0] sh_next;
  logic              ov_q;
  logic [WORD_W-1:0] od_q;

  always_comb begin
    sh_next  = {sh_q[WORD_W-2:0], din};
    stall    = ov_q && !out_ready;
    last_bit = rise && (bits_q == BIT_LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits_q <= '0;
      lane_q <= '0;
      sh_q   <= '0;
      ov_q   <= 1'b0;
      od_q   <= '0;
    end else if (clear) begin
      bits_q <= '0;
      lane_q <= '0;
      sh_q   <= '0;
      ov_q   <= 1'b0;
    end else begin
      if (ov_q && out_ready) begin
        ov_q <= 1'b0;
      end
      if (rise) begin
        sh_q   <= sh_next;
        bits_q <= bits_q + 1'b1;
        if (lane_q == LANE_LAST) begin
          lane_q <= '0;
          od_q   <= sh_next;
          ov_q   <= 1'b1;
        end else begin
          lane_q <= lane_q + 1'b1;
        end
      end
    end
  end

  assign out_valid = ov_q;
  assign out_data  = od_q;

endmodule

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader
  import serial_cfg_loader_pkg::*;
#(
  parameter int unsigned DIV         = 2,
  parameter int unsigned INIT_CYCLES = 4,
  parameter int unsigned IMAGE_BITS  = 64,
  parameter int unsigned WORD_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        mode_sel,
  input  logic              reconfig_n,
  input  logic              cfg_din,
  output logic              cfg_clk,
  output logic              init_n,
  output logic              done,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data
);

  ld_state_t state;
  logic      shifting;
  logic      stall;
  logic      rise;
  logic      last_bit;

  cfgl_sequencer #(
    .INIT_CYCLES(INIT_CYCLES)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .reconfig_n(reconfig_n),
    .mode_sel  (mode_sel),
    .last_bit  (last_bit),
    .state     (state),
    .init_n    (init_n),
    .done      (done),
    .shifting  (shifting)
  );

  cfgl_clkgen #(
    .DIV(DIV)
  ) u_clk (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (shifting),
    .stall  (stall),
    .cfg_clk(cfg_clk),
    .rise   (rise)
  );

  cfgl_deser #(
    .WORD_W    (WORD_W),
    .IMAGE_BITS(IMAGE_BITS)
  ) u_deser (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (!reconfig_n),
    .rise     (rise),
    .din      (cfg_din),
    .out_ready(out_ready),
    .out_valid(out_valid),
    .out_data (out_data),
    .stall    (stall),
    .last_bit (last_bit)
  );

endmodule

// File: rtl/serial_cfg_loader_chk.sv
module serial_cfg_loader_chk #(
  parameter int unsigned WORD_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reconfig_n,
  input logic              cfg_clk,
  input logic              init_n,
  input logic              done,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_data
);

  AST_CLK_NEEDS_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    !init_n |-> !cfg_clk); // R4

  AST_RISE_WHILE_LOADING: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_clk) |-> init_n && !$past(done)); // R3

  AST_CLK_QUIET_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done && $past(done) |-> !cfg_clk); // R5

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    done && reconfig_n |=> done); // R5

  AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && reconfig_n |=> out_valid && $stable(out_data)); // R6

  AST_NO_RISE_IN_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && reconfig_n |=> !$rose(cfg_clk)); // R7

  AST_RECONFIG_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    !reconfig_n |=> !out_valid && !done && !init_n); // R8

endmodule

bind serial_cfg_loader serial_cfg_loader_chk #(.WORD_W(WORD_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reconfig_n(reconfig_n),
  .cfg_clk   (cfg_clk),
  .init_n    (init_n),
  .done      (done),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data)
);

// File: tb/serial_cfg_loader_tb.sv
module serial_cfg_loader_tb;

  localparam int DIV = 2;
  localparam int INIT_CYCLES = 4;
  localparam int IMAGE_BITS = 64;
  localparam int NBYTES = IMAGE_BITS / 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] mode_sel = 3'b000;
  logic       reconfig_n = 1'b1;
  logic       cfg_din = 1'b0;
  logic       out_ready = 1'b1;
  logic       cfg_clk, init_n, done, out_valid;
  logic [7:0] out_data;

  always #10 clk = ~clk;

  serial_cfg_loader #(.DIV(DIV), .INIT_CYCLES(INIT_CYCLES), .IMAGE_BITS(IMAGE_BITS)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .reconfig_n(reconfig_n),
    .cfg_din(cfg_din), .cfg_clk(cfg_clk), .init_n(init_n), .done(done),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  int total = 0;
  int bad = 0;
  logic [7:0] image [NBYTES];
  logic [7:0] got [$];
  int addr = 0;
  logic pclk = 1'b0;
  int rise_cnt = 0;
  bit started = 0;

  // behavioural reference: 0 idle, 1 memory reset, 2 loading, 3 finished
  int m_st = 0, m_arm = 1, m_ic = 0, m_ph = 0, m_ck = 0, m_bits = 0, m_sh = 0, m_ov = 0, m_od = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    int n_st, n_arm, n_ic, n_ph, n_ck, n_bits, n_sh, n_ov, n_od;
    started <= 1;
    if (rst_n && reconfig_n && out_valid && out_ready) got.push_back(out_data);
    n_st = m_st; n_arm = m_arm; n_ic = m_ic; n_ph = m_ph; n_ck = m_ck;
    n_bits = m_bits; n_sh = m_sh; n_ov = m_ov; n_od = m_od;
    if (!rst_n || !reconfig_n) begin
      n_st = 0; n_arm = 1; n_ic = 0; n_ph = 0; n_ck = 0; n_bits = 0; n_sh = 0; n_ov = 0;
      if (!rst_n) n_od = 0;
    end else begin
      if (m_ov == 1 && out_ready) n_ov = 0;
      case (m_st)
        0: if (m_arm == 1) begin
             n_arm = 0;
             if (mode_sel == 3'b000) begin n_st = 1; n_ic = 0; end
           end
        1: if (m_ic == INIT_CYCLES - 1) n_st = 2; else n_ic = m_ic + 1;
        2: if (m_ph == DIV - 1) begin
             if (m_ck == 1) begin n_ck = 0; n_ph = 0; end
             else if (!(m_ov == 1 && !out_ready)) begin
               n_ck = 1; n_ph = 0;
               n_sh = ((m_sh * 2) + int'(cfg_din)) % 256;
               n_bits = m_bits + 1;
               if (n_bits % 8 == 0) begin n_od = n_sh; n_ov = 1; end
               if (n_bits == IMAGE_BITS) n_st = 3;
             end
           end else n_ph = m_ph + 1;
        default: begin n_ck = 0; n_ph = 0; end
      endcase
    end
    m_st = n_st; m_arm = n_arm; m_ic = n_ic; m_ph = n_ph; m_ck = n_ck;
    m_bits = n_bits; m_sh = n_sh; m_ov = n_ov; m_od = n_od;
  end

  // compare on every cycle, then let the memory model react
  always @(negedge clk) begin
    if (started) begin
      check(cfg_clk == m_ck[0], "R3 cfg_clk", int'(cfg_clk), m_ck);
      check(init_n == (m_st >= 2), "R4 init_n", int'(init_n), int'(m_st >= 2));
      check(done == (m_st == 3), "R5 done", int'(done), int'(m_st == 3));
      check(out_valid == m_ov[0], "R6 out_valid", int'(out_valid), m_ov);
      if (m_ov == 1) check(out_data == m_od[7:0], "R2 out_data", int'(out_data), m_od);
    end
    if (!init_n) addr = 0;
    else if (cfg_clk && !pclk) begin
      addr = (addr + 1) % IMAGE_BITS;
      rise_cnt++;
    end
    pclk = cfg_clk;
    cfg_din = done ? 1'b0 : image[addr / 8][7 - (addr % 8)];
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic pulse_reconfig();
    @(negedge clk); #1; reconfig_n = 1'b0;
    tick(3);
    reconfig_n = 1'b1;
    got.delete();
  endtask

  task automatic check_words(input string req);
    check(got.size() == NBYTES, req, got.size(), NBYTES);
    for (int i = 0; i < NBYTES && i < got.size(); i++)
      check(got[i] == image[i], req, int'(got[i]), int'(image[i]));
  endtask

  task automatic wait_done();
    for (int i = 0; i < 2000 && !done; i++) begin
      @(negedge clk); #1;
    end
  endtask

  initial begin
    for (int i = 0; i < NBYTES; i++) image[i] = 8'(i * 37 + 90);
    image[0] = 8'h80; // R2: lone first bit must land in bit 7
    tick(4);
    check(!cfg_clk && !init_n && !done && !out_valid, "R4 reset state", int'(init_n), 0);
    rst_n = 1'b1;
    // plain load with ready always high
    wait_done();
    tick(20);
    check(done == 1'b1, "R5 done after image", int'(done), 1);
    check(rise_cnt == IMAGE_BITS, "R3 edge count", rise_cnt, IMAGE_BITS);
    check_words("R2 words in order");
    // load under irregular back-pressure
    for (int i = 0; i < NBYTES; i++) image[i] = 8'(i * 91 + 13);
    pulse_reconfig();
    for (int c = 0; c < 3000 && !done; c++) begin
      out_ready = ((c % 7) == 0) || ((c % 11) == 3);
      tick(1);
    end
    out_ready = 1'b1;
    tick(20);
    check_words("R7 words under stall");
    // nonzero mode: stays idle even when mode later clears
    mode_sel = 3'b010;
    pulse_reconfig();
    rise_cnt = 0;
    tick(40);
    mode_sel = 3'b000;
    tick(60);
    check(rise_cnt == 0, "R1 no clock in other mode", rise_cnt, 0);
    check(!init_n && !done, "R1 held idle", int'(init_n), 0);
    // interrupted load with a pending word, then full restart
    pulse_reconfig();
    out_ready = 1'b0;
    tick(60);
    check(out_valid == 1'b1, "R6 word pending", int'(out_valid), 1);
    pulse_reconfig();
    check(!out_valid && !done, "R8 flushed", int'(out_valid), 0);
    out_ready = 1'b1;
    wait_done();
    tick(10);
    check_words("R8 restart from first bit");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #3000000;
    bad++; total++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule